// File: doc/BRIEF.md
# Coded Clock Output Divider with Glitch-Free Enable

This block sits behind a frequency synthesizer's oscillator and turns the oscillator-rate clock into a set of identical differential clock outputs. A three-bit ratio code selects one of several power-of-two division ratios, divide-by-1 included. Every ratio gives a square wave with equal high and low time. All pairs carry the same divided signal in the same phase. Each pair has a true line and a complement line.

An output enable turns the outputs on and off. It is first brought into the oscillator domain and then applied on a falling oscillator edge, so no short pulse reaches a pin. A synchronous active-low master reset restarts the divider. While reset is low, the outputs are held in the disabled state. A new ratio code is taken only where the divided output falls, so a high phase is never cut short.

Top module: `vco_outdiv`

## Requirements
- R1: The code on `n_code` selects the ratio as follows: 3'b000 gives /2, 3'b001 gives /4, 3'b010 gives /8, 3'b011 gives /16, 3'b100 gives /1, 3'b101 gives /2, 3'b110 gives /4 and 3'b111 gives /8.
- R2: For every ratio R of 2 or more, the output is low for R/2 rising edges of `clk_vco` and then high for R/2 rising edges. After a period boundary the low half comes first. The output changes only just after a rising edge.
- R3: At ratio /1 an enabled output is high while `clk_vco` is high and low while it is low.
- R4: `oe` is sampled on a rising edge of `clk_vco` and passes through two rising-edge synchronizer stages. The outputs then enable or disable on the falling edge that follows the second of those stages.
- R5: While disabled, every true output is 0 and every complement output is 1.
- R6: While `rst_n` is low, every true output is 0 and every complement output is 1. At each rising edge with `rst_n` low, the divider restarts at the start of a low half and loads the ratio from `n_code`. The synchronized enable clears, so the outputs stay disabled until the R4 latency has passed after release.
- R7: A new ratio code takes effect only at the rising edge where the divided output falls (the end of a high half). At ratio /1 this is any rising edge, and a new ratio of 2 or more then begins with its low half.
- R8: All `NUM_PAIRS` true outputs are equal at all times, and each complement output is the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator-rate clock to be divided |
| rst_n | input | 1 | Synchronous active-low master reset |
| n_code | input | 3 | Output division ratio code |
| oe | input | 1 | Output enable, asynchronous to `clk_vco` |
| clk_out_p | output | NUM_PAIRS | True output of each pair |
| clk_out_n | output | NUM_PAIRS | Complement output of each pair |

## Verification
The bench samples the outputs once in the high half and once in the low half of each oscillator cycle. It compares them with a behavioural period-and-phase model, so a ratio that is off by one half, or a /1 path that holds the output at a level, shows as a wrong level within a few samples. Ratio codes are changed in the middle of a high phase, both between divided ratios and into and out of /1. A design that loads the code at once would cut a high phase short, or would start the new ratio on its high half. The enable is toggled while the clock runs, and a design with the wrong number of synchronizer stages, or one that switches on a rising edge, is off by a half or a whole cycle at the enable boundary. Reset is applied in the middle of a period, which catches a counter that keeps its phase or outputs that keep toggling.

// File: rtl/odiv_pkg.sv
// Package odiv_pkg
// Holds the ratio-code type and the decoder from code to a shift amount
// (the ratio is 1 << shift). The encoding is fixed by the block's pin
// definition, so the code width is not a parameter.
package odiv_pkg;
    localparam int CODE_W  = 3;
    localparam int SHIFT_W = 3;

    typedef logic [CODE_W-1:0]  ncode_t;
    typedef logic [SHIFT_W-1:0] shift_t;

    // Maps a ratio code to log2 of its division ratio.
    function automatic shift_t code_to_shift(input ncode_t code);
        if (code[2]) begin
            return {1'b0, code[1:0]};
        end else begin
            return shift_t'(code[1:0]) + shift_t'(1);
        end
    endfunction
endpackage

// File: rtl/odiv_oe_gate.sv
// Module odiv_oe_gate
// Brings the asynchronous enable into the clk_vco domain through a
// rising-edge synchronizer chain, then updates the gate on the falling edge
// so the gate never changes while a divided high phase is starting.
// Assumes rst_n is synchronous to clk_vco and SYNC_STAGES >= 1.
module odiv_oe_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_vco,
    input  logic rst_n,
    input  logic oe,
    output logic gate_en
);
    logic [SYNC_STAGES-1:0] sync_q;

    // Synchronizer chain for the enable, cleared by reset.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= oe;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Gate update on the falling edge, after the rising edge that settled it.
    always_ff @(negedge clk_vco) begin
        if (!rst_n) begin
            gate_en <= 1'b0;
        end else begin
            gate_en <= sync_q[SYNC_STAGES-1];
        end
    end

    // R4: the gate only opens for an enable sampled SYNC_STAGES edges back
    assert_gate_rise_R4: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $rose(gate_en) |-> $past(oe, SYNC_STAGES));

    // R4: the gate only closes for a disable sampled SYNC_STAGES edges back
    assert_gate_fall_R4: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $fell(gate_en) |-> !$past(oe, SYNC_STAGES));
endmodule

// File: rtl/odiv_counter.sv
// Module odiv_counter
// Power-of-two divider with a 50% duty cycle. A half-period counter toggles
// div_q every 2^(shift-1) rising edges. The active shift is reloaded from
// the code only where div_q falls, or on any edge in bypass (/1) mode.
// Assumes the decoded shift never exceeds MAX_SHIFT.
module odiv_counter
    import odiv_pkg::*;
#(
    parameter int MAX_SHIFT = 4
) (
    input  logic   clk_vco,
    input  logic   rst_n,
    input  ncode_t n_code,
    output logic   div_q,
    output logic   bypass
);
    localparam int CNT_W = MAX_SHIFT;

    shift_t           act_shift;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic             half_end;

    // Last count of a half period for the active ratio.
    always_comb begin
        half_m1  = (CNT_W'(1) << (act_shift - shift_t'(1))) - CNT_W'(1);
        half_end = (cnt == half_m1);
    end

    // Counter, output toggle and boundary-only ratio reload.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) begin
            cnt       <= '0;
            div_q     <= 1'b0;
            act_shift <= code_to_shift(n_code);
        end else if (act_shift == '0) begin
            cnt       <= '0;
            div_q     <= 1'b0;
            act_shift <= code_to_shift(n_code);
        end else if (half_end) begin
            cnt <= '0;
            if (div_q) begin
                div_q     <= 1'b0;
                act_shift <= code_to_shift(n_code);
            end else begin
                div_q <= 1'b1;
            end
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign bypass = (act_shift == '0);

    // R2: the half-period counter never passes the active half length
    assert_half_bound_R2: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (act_shift != '0) |-> (cnt <= half_m1));

    // R7: the ratio holds unless this edge ends a high half
    assert_code_hold_R7: assert property (@(posedge clk_vco) disable iff (!rst_n)
        ((act_shift != '0) && !(div_q && half_end)) |=> $stable(act_shift));
endmodule

// File: rtl/odiv_fanout.sv
// Module odiv_fanout
// Copies one gated clock onto NUM_PAIRS true/complement pairs. Assumes the
// source and the enable are free of glitches at the points where they change.
module odiv_fanout #(
    parameter int NUM_PAIRS = 6
) (
    input  logic                 src,
    input  logic                 en,
    output logic [NUM_PAIRS-1:0] out_p,
    output logic [NUM_PAIRS-1:0] out_n
);
    logic gated;

    assign gated = src & en;

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        // One differential pair driven from the shared gated signal.
        assign out_p[i] = gated;
        assign out_n[i] = ~gated;
    end
endmodule

// File: rtl/vco_outdiv.sv
// Module vco_outdiv
// Top level of the coded output divider. It selects between the raw clock
// (/1) and the counter output, gates the result with the synchronized enable
// and with reset, and fans it out to the output pairs.
// Assumes rst_n is synchronous to clk_vco. oe may be asynchronous.
module vco_outdiv
    import odiv_pkg::*;
#(
    parameter int NUM_PAIRS   = 6,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_SHIFT   = 4
) (
    input  logic                 clk_vco,
    input  logic                 rst_n,
    input  logic [2:0]           n_code,
    input  logic                 oe,
    output logic [NUM_PAIRS-1:0] clk_out_p,
    output logic [NUM_PAIRS-1:0] clk_out_n
);
    logic div_q;
    logic bypass;
    logic gate_en;
    logic fast_clk;
    logic out_en;

    odiv_counter #(.MAX_SHIFT(MAX_SHIFT)) u_counter (
        .clk_vco (clk_vco),
        .rst_n   (rst_n),
        .n_code  (n_code),
        .div_q   (div_q),
        .bypass  (bypass)
    );

    odiv_oe_gate #(.SYNC_STAGES(SYNC_STAGES)) u_oe_gate (
        .clk_vco (clk_vco),
        .rst_n   (rst_n),
        .oe      (oe),
        .gate_en (gate_en)
    );

    // Ratio source select: the raw clock in /1 mode, the counter otherwise.
    assign fast_clk = bypass ? clk_vco : div_q;
    // The outputs are on only when enabled and out of reset.
    assign out_en   = gate_en & rst_n;

    odiv_fanout #(.NUM_PAIRS(NUM_PAIRS)) u_fanout (
        .src   (fast_clk),
        .en    (out_en),
        .out_p (clk_out_p),
        .out_n (clk_out_n)
    );

    // R5: a closed gate leaves every pair at true 0 and complement 1
    assert_disabled_state_R5: assert property (@(posedge clk_vco) disable iff (!rst_n)
        !gate_en |-> (clk_out_p == '0 && clk_out_n == '1));

    // R8: all pairs agree and every complement is inverted
    assert_pairs_match_R8: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (clk_out_p == {NUM_PAIRS{clk_out_p[0]}}) && (clk_out_n == ~clk_out_p));
endmodule

// File: tb/vco_outdiv_tb.sv
// Bench for vco_outdiv: behavioural period/phase model checked in both clock halves.
module vco_outdiv_tb;
    localparam int NP = 6;

    logic          clk_vco = 1'b0;
    logic          rst_n   = 1'b0;
    logic [2:0]    n_code  = 3'b000;
    logic          oe      = 1'b0;
    logic [NP-1:0] clk_out_p;
    logic [NP-1:0] clk_out_n;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    running  = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R6";

    // Reference model state.
    int m_ratio = 2;
    int m_ph    = 0;
    bit q1 = 0, q2 = 0, m_gate = 0;

    vco_outdiv #(.NUM_PAIRS(NP)) u_dut (
        .clk_vco   (clk_vco),
        .rst_n     (rst_n),
        .n_code    (n_code),
        .oe        (oe),
        .clk_out_p (clk_out_p),
        .clk_out_n (clk_out_n)
    );

    always #4 clk_vco = ~clk_vco;

    // R1 ratio table.
    function automatic int ratio_of(input logic [2:0] c);
        case (c)
            3'b000: return 2;
            3'b001: return 4;
            3'b010: return 8;
            3'b011: return 16;
            3'b100: return 1;
            3'b101: return 2;
            3'b110: return 4;
            default: return 8;
        endcase
    endfunction

    // Model: phase advance, boundary-only reload, enable delay line.
    always @(posedge clk_vco) begin
        if (!rst_n) begin
            m_ratio = ratio_of(n_code);
            m_ph    = 0;
            q1      = 0;
            q2      = 0;
        end else begin
            q2 = q1;
            q1 = oe;
            if (m_ratio == 1) begin
                m_ratio = ratio_of(n_code);
                m_ph    = 0;
            end else begin
                m_ph++;
                if (m_ph == m_ratio) begin
                    m_ph    = 0;
                    m_ratio = ratio_of(n_code);
                end
            end
        end
    end

    always @(negedge clk_vco) m_gate = rst_n ? q2 : 1'b0;

    task automatic check_outputs(input bit clk_high);
        bit lvl;
        logic [NP-1:0] exp_p, exp_n;
        lvl   = (m_ratio == 1) ? clk_high : (m_ph >= m_ratio / 2);
        lvl   = lvl & m_gate & rst_n;
        exp_p = {NP{lvl}};
        exp_n = ~exp_p;
        n_checks++;
        if (clk_out_p !== exp_p || clk_out_n !== exp_n) begin
            n_fails++;
            $display("FAIL %s/R8 t=%0t p=%b n=%b expected p=%b n=%b",
                     cur_req, $time, clk_out_p, clk_out_n, exp_p, exp_n);
        end
    endtask

    always @(posedge clk_vco) if (running) begin #2; check_outputs(1'b1); end
    always @(negedge clk_vco) if (running) begin #2; check_outputs(1'b0); end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk_vco);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        finish_run();
    end

    initial begin
        running = 1'b1;
        // R6: outputs quiet under reset
        cur_req = "R6";
        wait_cycles(4);
        rst_n = 1'b1;
        // R4: enable latency after release
        cur_req = "R4";
        oe = 1'b1;
        wait_cycles(10);
        // R1 R2: every ratio code in turn
        for (int c = 0; c < 8; c++) begin
            cur_req = (c == 4) ? "R3" : "R1 R2";
            n_code  = 3'(c);
            wait_cycles(40);
        end
        // R7: changes in the middle of a high half
        cur_req = "R7";
        n_code = 3'b011;
        wait_cycles(40);
        n_code = 3'b101;
        wait_cycles(20);
        n_code = 3'b011;
        wait_cycles(9);
        n_code = 3'b100;
        wait_cycles(30);
        n_code = 3'b111;
        wait_cycles(1);
        n_code = 3'b010;
        wait_cycles(30);
        // R5 R4: disable and re-enable while running
        cur_req = "R5";
        oe = 1'b0;
        wait_cycles(12);
        cur_req = "R4";
        oe = 1'b1;
        wait_cycles(3);
        oe = 1'b0;
        wait_cycles(1);
        oe = 1'b1;
        wait_cycles(20);
        n_code = 3'b100;
        wait_cycles(10);
        cur_req = "R5";
        oe = 1'b0;
        wait_cycles(8);
        oe = 1'b1;
        wait_cycles(8);
        // R6: reset in mid-period, then restart with /16
        cur_req = "R6";
        n_code = 3'b011;
        wait_cycles(13);
        rst_n = 1'b0;
        wait_cycles(5);
        rst_n = 1'b1;
        wait_cycles(40);
        running = 1'b0;
        #10;
        finish_run();
    end
endmodule